// File: doc/BRIEF.md
# Precise Exception Tracker for a Five-Stage Pipeline

This block is the control slice of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) that keeps exceptions precise. The block owns the fetch program counter. Every instruction it launches carries a valid bit, its own PC, a store flag and an exception cause. Fault pins from fetch, execute and memory only mark the cause of the instruction that sits in that stage. No redirect happens until that instruction reaches writeback. At that point the block latches the instruction's PC and cause into the exception registers, steers fetch to the handler vector and discards every younger instruction in flight. The result is that the oldest faulting instruction always wins, even when a younger one faulted first in time.

An external interrupt request does not stop anything directly. It replaces the fetched instruction with a no-op that already carries the interrupt cause, and that no-op then travels the pipe like any other faulting instruction. The instruction memory, translation buffers, ALU and data memory are not part of the block; they are represented only by their fault pins and by the store flag that comes with each fetched instruction.

Top module: `exc_tracker`

## Requirements
- R1: While reset is asserted, `fetch_pc` equals the RESET_PC parameter, `epc` and `epc_cause` are zero, and `wb_valid`, `trap`, `rf_we` and `mem_we` are low.
- R2: Without faults, `fetch_pc` advances by 4 on every clock edge. An instruction fetched at PC P appears at writeback four edges later with `wb_valid` high and `wb_pc` equal to P.
- R3: Cause codes for the fetch stage are: interrupt 5, instruction translation fault 2, bad instruction 1. When several fetch pins are high in one cycle, the priority is interrupt, then translation fault, then bad instruction. An interrupt turns the fetched slot into a no-op that is not a store.
- R4: `ex_overflow` marks the instruction in execute with cause 3, and `mem_dtlb` marks the instruction in memory with cause 4. An instruction keeps the first cause it was given, and later fault pins do not change it. Code 0 means no fault.
- R5: `trap` is high only in the cycle when a valid instruction with a nonzero cause is at writeback. For an instruction fetched in cycle c, that is cycle c+4. `trap` is never high earlier.
- R6: On the clock edge that ends a trap cycle, `epc` takes `wb_pc` and `epc_cause` takes that instruction's cause.
- R7: On the same edge, `fetch_pc` becomes the VECTOR parameter.
- R8: On the same edge, every younger instruction is discarded. `wb_valid` and `trap` stay low for the next four cycles, so the oldest fault wins and younger faults are lost.
- R9: `rf_we` is high only for a valid, fault-free, non-store instruction at writeback. `mem_we` is high only for a valid, fault-free store in memory that gets no `mem_dtlb` in that cycle, and only while no trap is at writeback.
- R10: Outside a trap edge, `epc` and `epc_cause` keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_store | input | 1 | Instruction at `fetch_pc` is a store |
| fetch_bad | input | 1 | Instruction at `fetch_pc` is undecodable |
| fetch_itlb | input | 1 | Translation fault on the fetch of `fetch_pc` |
| irq_req | input | 1 | External interrupt: inject a faulting no-op in place of this fetch |
| ex_overflow | input | 1 | Arithmetic overflow for the instruction in execute |
| mem_dtlb | input | 1 | Data translation fault for the instruction in memory |
| fetch_pc | output | XLEN | PC being fetched this cycle |
| wb_valid | output | 1 | A valid instruction is at writeback |
| wb_pc | output | XLEN | PC of the instruction at writeback |
| trap | output | 1 | Writeback instruction faulted; redirect on this edge |
| rf_we | output | 1 | Register file write permitted |
| mem_we | output | 1 | Data memory write permitted |
| epc | output | XLEN | Saved PC of the last trapping instruction |
| epc_cause | output | 3 | Cause code of the last trap |

## Verification
The bench builds the block with XLEN 16, RESET_PC 0x0100 and VECTOR 0x0040. The narrow PC keeps the expected arithmetic simple, and after every trap it shows fetch jumping to a vector that is far from the sequential stream. It sweeps all 36 pairings of fault kind (none or one of five) on an older instruction and on the store that follows it. This covers the cases where the younger fault is raised earlier in time, where it is raised in the same cycle, and where only the younger instruction faults. Each pairing also checks the write enables of both instructions. Directed runs add the fetch-pin priority and causes that stay fixed while later fault pins fire.

// File: rtl/exc_trk_pkg.sv
package exc_trk_pkg;
  typedef enum logic [2:0] {
    C_NONE  = 3'd0,
    C_BADOP = 3'd1,
    C_ITLB  = 3'd2,
    C_OVF   = 3'd3,
    C_DTLB  = 3'd4,
    C_IRQ   = 3'd5
  } cause_e;
endpackage

// File: rtl/exc_trk_fetch.sv
module exc_trk_fetch
  import exc_trk_pkg::*;
(
  input  logic   irq_req,
  input  logic   fetch_itlb,
  input  logic   fetch_bad,
  input  logic   fetch_store,
  output cause_e cause,
  output logic   store
);
  // R3: interrupt outranks instruction translation, which outranks bad opcode
  always_comb begin
    if (irq_req)         cause = C_IRQ;
    else if (fetch_itlb) cause = C_ITLB;
    else if (fetch_bad)  cause = C_BADOP;
    else                 cause = C_NONE;
  end

  // an injected interrupt slot is a no-op, never a store
  assign store = fetch_store & ~irq_req;
endmodule

// File: rtl/exc_trk_stage.sv
module exc_trk_stage
  import exc_trk_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            in_valid,
  input  logic            in_store,
  input  logic [XLEN-1:0] in_pc,
  input  cause_e          in_cause,
  input  cause_e          raise,
  output logic            q_valid,
  output logic            q_store,
  output logic [XLEN-1:0] q_pc,
  output cause_e          q_cause
);
  logic   n_valid;
  logic   load_en;
  cause_e n_cause;

  always_comb begin
    n_valid = in_valid & ~flush;
    load_en = n_valid;
    // R4: first recorded cause sticks; a stage fault only lands on a clean instruction
    if (in_cause != C_NONE) n_cause = in_cause;
    else                    n_cause = raise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_store <= 1'b0;
      q_pc    <= '0;
      q_cause <= C_NONE;
    end else begin
      q_valid <= n_valid;
      if (load_en) begin
        q_store <= in_store;
        q_pc    <= in_pc;
        q_cause <= n_cause;
      end
    end
  end

  p_sticky_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flush && in_cause != C_NONE) |=> (q_cause == $past(in_cause)));

  p_raise_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flush && in_cause == C_NONE && raise != C_NONE) |=> (q_cause == $past(raise)));

  p_flush_kills_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !q_valid);
endmodule

// File: rtl/exc_trk_pc.sv
module exc_trk_pc
  import exc_trk_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter logic [XLEN-1:0] VECTOR   = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap,
  input  logic [XLEN-1:0] wb_pc,
  input  cause_e          wb_cause,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] epc,
  output cause_e          epc_cause
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] pc_n;
  logic            epc_en;

  always_comb begin
    pc_n   = trap ? VECTOR : (pc + STEP);
    epc_en = trap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc        <= RESET_PC;
      epc       <= '0;
      epc_cause <= C_NONE;
    end else begin
      pc <= pc_n;
      if (epc_en) begin
        epc       <= wb_pc;
        epc_cause <= wb_cause;
      end
    end
  end

  p_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> (pc == VECTOR));

  p_sequential_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !trap |=> (pc == $past(pc) + STEP));

  p_save_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> (epc == $past(wb_pc) && epc_cause == $past(wb_cause)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !trap |=> ($stable(epc) && $stable(epc_cause)));
endmodule

// File: rtl/exc_tracker.sv
module exc_tracker
  import exc_trk_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = XLEN'(32'h0000_1000),
  parameter logic [XLEN-1:0] VECTOR   = XLEN'(32'h0000_0080)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_store,
  input  logic            fetch_bad,
  input  logic            fetch_itlb,
  input  logic            irq_req,
  input  logic            ex_overflow,
  input  logic            mem_dtlb,
  output logic [XLEN-1:0] fetch_pc,
  output logic            wb_valid,
  output logic [XLEN-1:0] wb_pc,
  output logic            trap,
  output logic            rf_we,
  output logic            mem_we,
  output logic [XLEN-1:0] epc,
  output logic [2:0]      epc_cause
);
  // pipeline registers after fetch: decode, execute, memory, writeback
  localparam int NREG = 4;
  localparam int S_E  = 2;
  localparam int S_M  = 3;
  localparam int S_W  = 4;

  logic [NREG:0]   st_v;
  logic [NREG:0]   st_s;
  logic [XLEN-1:0] st_pc [NREG+1];
  cause_e          st_c  [NREG+1];
  cause_e          raise [NREG];
  cause_e          f_cause;
  cause_e          saved_cause;
  logic            f_store;
  logic            wb_fault;

  exc_trk_fetch u_fetch (
    .irq_req     (irq_req),
    .fetch_itlb  (fetch_itlb),
    .fetch_bad   (fetch_bad),
    .fetch_store (fetch_store),
    .cause       (f_cause),
    .store       (f_store)
  );

  // slot 0 is the instruction being fetched this cycle
  assign st_v[0]  = 1'b1;
  assign st_s[0]  = f_store;
  assign st_pc[0] = fetch_pc;
  assign st_c[0]  = C_NONE;

  // fault raised by the stage an instruction is leaving
  assign raise[0]     = f_cause;
  assign raise[1]     = C_NONE;
  assign raise[S_E-0] = ex_overflow ? C_OVF  : C_NONE;
  assign raise[S_M-0] = mem_dtlb    ? C_DTLB : C_NONE;

  for (genvar k = 1; k <= NREG; k++) begin : g_stage
    exc_trk_stage #(.XLEN(XLEN)) u_st (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (trap),
      .in_valid (st_v[k-1]),
      .in_store (st_s[k-1]),
      .in_pc    (st_pc[k-1]),
      .in_cause (st_c[k-1]),
      .raise    (raise[k-1]),
      .q_valid  (st_v[k]),
      .q_store  (st_s[k]),
      .q_pc     (st_pc[k]),
      .q_cause  (st_c[k])
    );
  end

  exc_trk_pc #(.XLEN(XLEN), .RESET_PC(RESET_PC), .VECTOR(VECTOR)) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .trap      (trap),
    .wb_pc     (st_pc[S_W]),
    .wb_cause  (st_c[S_W]),
    .pc        (fetch_pc),
    .epc       (epc),
    .epc_cause (saved_cause)
  );

  always_comb begin
    wb_fault  = st_c[S_W] != C_NONE;
    trap      = st_v[S_W] & wb_fault;
    wb_valid  = st_v[S_W];
    wb_pc     = st_pc[S_W];
    rf_we     = st_v[S_W] & ~wb_fault & ~st_s[S_W];
    mem_we    = st_v[S_M] & st_s[S_M] & (st_c[S_M] == C_NONE) & ~mem_dtlb & ~trap;
    epc_cause = saved_cause;
  end

  p_flush_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> (st_v[NREG:1] == '0));

  p_cause_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> (epc_cause != 3'd0));

  p_store_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_v[S_M] && mem_dtlb) |-> !mem_we);
endmodule

// File: tb/exc_tracker_test.sv
`timescale 1ns/100ps
module exc_tracker_test;
  localparam int              XLEN = 16;
  localparam logic [XLEN-1:0] RPC  = 16'h0100;
  localparam logic [XLEN-1:0] VEC  = 16'h0040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_store = 1'b0, fetch_bad = 1'b0, fetch_itlb = 1'b0, irq_req = 1'b0;
  logic ex_overflow = 1'b0, mem_dtlb = 1'b0;
  logic [XLEN-1:0] fetch_pc, wb_pc, epc;
  logic wb_valid, trap, rf_we, mem_we;
  logic [2:0] epc_cause;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [XLEN-1:0] exp_pc;
  logic [XLEN-1:0] exp_epc;
  logic [2:0]      exp_cause;

  always #2.5 clk = ~clk;

  exc_tracker #(.XLEN(XLEN), .RESET_PC(RPC), .VECTOR(VEC)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_store(fetch_store), .fetch_bad(fetch_bad),
    .fetch_itlb(fetch_itlb), .irq_req(irq_req), .ex_overflow(ex_overflow),
    .mem_dtlb(mem_dtlb), .fetch_pc(fetch_pc), .wb_valid(wb_valid), .wb_pc(wb_pc),
    .trap(trap), .rf_we(rf_we), .mem_we(mem_we), .epc(epc), .epc_cause(epc_cause)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  // f bits: {irq, itlb, bad, ovf, dtlb}
  task automatic drive(input logic [4:0] fetch_f, input logic st, input logic ovf, input logic dt);
    irq_req     = fetch_f[4];
    fetch_itlb  = fetch_f[3];
    fetch_bad   = fetch_f[2];
    fetch_store = st;
    ex_overflow = ovf;
    mem_dtlb    = dt;
    #1;
    chk(fetch_pc == exp_pc, "R2/R7 fetch_pc", int'(fetch_pc), int'(exp_pc));
  endtask

  task automatic edge_step(input bit trapping);
    @(posedge clk);
    #1;
    exp_pc = trapping ? VEC : exp_pc + 16'd4;
  endtask

  task automatic after_trap(input logic [XLEN-1:0] p, input logic [2:0] code);
    exp_epc   = p;
    exp_cause = code;
    chk(epc == p, "R6 epc", int'(epc), int'(p));
    chk(epc_cause == code, "R6 cause", int'(epc_cause), int'(code));
    for (int i = 0; i < 4; i++) begin
      drive(5'b0, 1'b0, 1'b0, 1'b0);
      chk(wb_valid == 1'b0, "R8 squashed wb_valid", int'(wb_valid), 0);
      chk(trap == 1'b0, "R8 no younger trap", int'(trap), 0);
      edge_step(1'b0);
    end
    drive(5'b0, 1'b0, 1'b0, 1'b0);
    chk(wb_valid && wb_pc == VEC, "R2/R7 vector retires", int'(wb_pc), int'(VEC));
    edge_step(1'b0);
  endtask

  // older instruction A (non-store) then store B; fa/fb = {irq,itlb,bad,ovf,dtlb}
  task automatic pair(input logic [4:0] fa, input logic [4:0] fb,
                      input logic [2:0] ca, input logic [2:0] cb);
    logic [XLEN-1:0] p;
    p = exp_pc;
    drive(fa, 1'b0, 1'b0, 1'b0);
    chk(trap == 1'b0, "R5 early trap c0", int'(trap), 0);
    edge_step(1'b0);
    drive(fb, 1'b1, 1'b0, 1'b0);
    chk(trap == 1'b0, "R5 early trap c1", int'(trap), 0);
    edge_step(1'b0);
    drive(5'b0, 1'b0, fa[1], 1'b0);
    chk(trap == 1'b0, "R5 early trap c2", int'(trap), 0);
    edge_step(1'b0);
    drive(5'b0, 1'b0, fb[1], fa[0]);
    chk(trap == 1'b0, "R5 early trap c3", int'(trap), 0);
    chk(mem_we == 1'b0, "R9 non-store A mem_we", int'(mem_we), 0);
    edge_step(1'b0);
    drive(5'b0, 1'b0, 1'b0, fb[0]);
    chk(trap == (ca != 0), "R5 trap at writeback A", int'(trap), int'(ca != 0));
    chk(wb_valid && wb_pc == p, "R2 wb_pc A", int'(wb_pc), int'(p));
    chk(rf_we == (ca == 0), "R9 rf_we A", int'(rf_we), int'(ca == 0));
    chk(mem_we == (ca == 0 && cb == 0), "R9 mem_we B", int'(mem_we), int'(ca == 0 && cb == 0));
    edge_step(ca != 0);
    if (ca != 0) begin
      after_trap(p, ca);
    end else begin
      drive(5'b0, 1'b0, 1'b0, 1'b0);
      chk(trap == (cb != 0), "R5 trap at writeback B", int'(trap), int'(cb != 0));
      chk(wb_valid && wb_pc == p + 16'd4, "R2 wb_pc B", int'(wb_pc), int'(p + 16'd4));
      chk(rf_we == 1'b0, "R9 store never writes rf", int'(rf_we), 0);
      edge_step(cb != 0);
      if (cb != 0) begin
        after_trap(p + 16'd4, cb);
      end else begin
        chk(epc == exp_epc, "R10 epc held", int'(epc), int'(exp_epc));
        chk(epc_cause == exp_cause, "R10 cause held", int'(epc_cause), int'(exp_cause));
      end
    end
  endtask

  function automatic logic [4:0] kind_pins(input int k);
    case (k)
      1: return 5'b00100;
      2: return 5'b01000;
      3: return 5'b00010;
      4: return 5'b00001;
      5: return 5'b10000;
      default: return 5'b00000;
    endcase
  endfunction

  initial begin
    exp_pc    = RPC;
    exp_epc   = '0;
    exp_cause = 3'd0;
    repeat (3) @(posedge clk);
    #1;
    chk(fetch_pc == RPC, "R1 reset pc", int'(fetch_pc), int'(RPC));
    chk(epc == 0 && epc_cause == 0, "R1 reset epc", int'(epc), 0);
    chk(!wb_valid && !trap && !rf_we && !mem_we, "R1 reset outputs",
        int'({wb_valid, trap, rf_we, mem_we}), 0);
    rst_n = 1'b1;
    edge_step(1'b0);
    // R2 fill: the first four cycles retire nothing
    for (int i = 0; i < 3; i++) begin
      drive(5'b0, 1'b0, 1'b0, 1'b0);
      chk(wb_valid == 1'b0, "R2 empty pipe", int'(wb_valid), 0);
      edge_step(1'b0);
    end
    // R8/R4/R9 exhaustive pairing of fault kinds on older and younger instruction
    for (int a = 0; a < 6; a++) begin
      for (int b = 0; b < 6; b++) begin
        pair(kind_pins(a), kind_pins(b), 3'(a), 3'(b));
      end
    end
    // R3 fetch priority
    pair(5'b11100, 5'b0, 3'd5, 3'd0);
    pair(5'b01100, 5'b0, 3'd2, 3'd0);
    // R4 first cause sticks through later faults
    pair(5'b00111, 5'b0, 3'd1, 3'd0);
    pair(5'b00011, 5'b0, 3'd3, 3'd0);
    pair(5'b0, 5'b01011, 3'd0, 3'd2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule